// File: doc/BRIEF.md
# Configurable Serial Character Transmitter

This block turns one parallel character into an asynchronous serial frame on a single output line. A host writes a byte into a holding stage. When the shifter is idle, that byte moves into the shift stage, which leaves the holding stage free for the next byte while the current frame is still going out. Each frame is a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a high stop period of one, one and a half or two bit times.

All timing comes from a baud tick that runs at sixteen times the bit rate. A 16-bit divisor counter derives this tick from a reference enable pulse on the system clock. With the reference enable tied high, the system clock itself is the reference. Live configuration inputs select the word length, parity, stop length and break. A freeze input aborts any frame in progress, holds the line at its idle high level and blocks new transfers until it is released.

Top module: `sertx_top`

## Requirements
- R1: The word length code `wlen_sel` selects 00=5, 01=6, 10=7 and 11=8 data bits. Each frame starts with one low bit, then sends the data bits least significant first. Bits of the written byte above the selected length are never sent.
- R2: When `par_en` is 1, one parity bit follows the last data bit. With `par_even`=1 it makes the count of ones over data plus parity even, and with `par_even`=0 it makes that count odd. When `par_en` is 0, no parity bit is sent.
- R3: When `par_stick` and `par_en` are both 1, the parity bit is a constant: 0 when `par_even`=1 and 1 when `par_even`=0.
- R4: The stop period lasts 16 ticks when `stop_sel`=0. When `stop_sel`=1 it lasts 32 ticks, or 24 ticks when the word length is 5. `xmit_empty` rises in the cycle after the last stop tick is used, provided no byte is waiting.
- R5: While `brk` is 1 and `freeze` is 0, `ser_out` is 0. A frame in progress keeps its normal timing underneath the break.
- R6: Every serial bit lasts exactly 16 baud ticks. A divisor D of 1 or more gives one tick for every D reference pulses. A divisor of 0 gives no ticks at all.
- R7: After reset, `ser_out`=1, `hold_empty`=1, `xmit_empty`=1 and `baud_tick`=0. The holding stage resets to all ones.
- R8: A byte written while the line is idle is moved to the shift stage on the next clock, and `hold_empty` returns to 1 while that frame is sent. A second byte written during the frame clears `hold_empty` and goes out after the first frame. `xmit_empty` is 1 only when both stages are empty.
- R9: While `freeze` is 1, `ser_out` is 1, any frame in progress is abandoned, and a written byte stays in the holding stage (`hold_empty`=0). The byte is sent in full once `freeze` returns to 0.
- R10: The divisor counter advances only on cycles where `baud_ref_en` is 1. With the enable tied high, ticks come every D clocks. With enable pulses every K clocks, ticks come every K*D clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_ref_en | input | 1 | Baud reference enable, one clock wide per pulse |
| divisor | input | 16 | Baud divisor, 0 stops the tick |
| wlen_sel | input | 2 | Word length code |
| stop_sel | input | 1 | Long stop period select |
| par_en | input | 1 | Parity enable |
| par_even | input | 1 | Even parity select / stick value select |
| par_stick | input | 1 | Stick parity |
| brk | input | 1 | Force line low |
| freeze | input | 1 | Abort and hold line idle |
| wr_en | input | 1 | Write strobe for the holding stage |
| wr_data | input | 8 | Byte to write |
| ser_out | output | 1 | Serial line |
| baud_tick | output | 1 | 16x bit-rate tick |
| hold_empty | output | 1 | Holding stage empty |
| xmit_empty | output | 1 | Holding and shift stages both empty |

## Verification
The assertions check, on every cycle, that the shifter never leaves a non-idle state without a tick, that freeze always returns it to idle, that the stop counter stays within its longest period, and that an idle shifter with a waiting byte starts a frame. They also check that ticks occur only on reference cycles and never with a zero divisor, and that the holding flag clears only after a write. The actual bit values of each frame and the parity and stick results can only be seen in the bench scenarios. The same holds for the exact stop lengths, break masking, back-to-back buffering and the tick period under pulsed references. The bench decodes the line at mid-bit using the tick output and compares each bit with a frame it builds independently.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_START = 3'd1,
    ST_DATA  = 3'd2,
    ST_PAR   = 3'd3,
    ST_STOP  = 3'd4
  } tx_state_e;

  // number of data bits for a word length code
  function automatic logic [3:0] data_len(input logic [1:0] code);
    return 4'd5 + {2'b00, code};
  endfunction

endpackage

// File: rtl/sertx_baud.sv
module sertx_baud #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_en,
  input  logic [DIV_W-1:0] divisor,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (ref_en) begin
      if (divisor == '0) begin
        cnt_d = '0;
      end else if (cnt_q <= DIV_W'(1)) begin
        cnt_d  = divisor;
        tick_d = 1'b1;
      end else begin
        cnt_d = cnt_q - DIV_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tick_o <= tick_d;
    end
  end

  // R6
  zero_div_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (divisor == '0) |=> !tick_o);

  // R10
  ref_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(ref_en));

endmodule

// File: rtl/sertx_hold.sv
module sertx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic [DATA_W-1:0] data_o,
  output logic              empty_o
);

  logic [DATA_W-1:0] data_d;
  logic              empty_d;

  always_comb begin
    data_d  = data_o;
    empty_d = empty_o;
    if (wr_en) begin
      data_d  = wr_data;
      empty_d = 1'b0;
    end else if (take) begin
      empty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '1;
      empty_o <= 1'b1;
    end else begin
      data_o  <= data_d;
      empty_o <= empty_d;
    end
  end

  // R8
  fill_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty_o) |-> $past(wr_en));

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
  import sertx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              freeze,
  input  logic              brk,
  input  logic [1:0]        wlen_sel,
  input  logic              stop_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic [DATA_W-1:0] hold_data,
  input  logic              hold_empty,
  output logic              take,
  output logic              busy,
  output logic              line_o
);

  localparam int SUB_W = $clog2(OVS);
  localparam int TC_W  = SUB_W + 2;
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [TC_W-1:0] BIT_LAST = TC_W'(OVS - 1);

  tx_state_e         state_q, state_d;
  logic [TC_W-1:0]   tcnt_q, tcnt_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] shf_q, shf_d;
  logic              par_q, par_d;

  logic [3:0]        nbits;
  logic [TC_W-1:0]   stop_last;
  logic [DATA_W-1:0] masked;
  logic              par_calc;
  logic              frame_line;

  always_comb begin
    nbits  = data_len(wlen_sel);
    masked = hold_data & (8'hFF >> (2'd3 - wlen_sel));
    if (par_stick) par_calc = ~par_even;
    else if (par_even) par_calc = ^masked;
    else par_calc = ~^masked;
    if (!stop_sel)            stop_last = TC_W'(OVS - 1);
    else if (wlen_sel == 2'b00) stop_last = TC_W'(OVS + OVS / 2 - 1);
    else                      stop_last = TC_W'(2 * OVS - 1);
  end

  assign take = (state_q == ST_IDLE) && !hold_empty && !freeze;
  assign busy = (state_q != ST_IDLE);

  always_comb begin
    state_d = state_q;
    tcnt_d  = tcnt_q;
    bit_d   = bit_q;
    shf_d   = shf_q;
    par_d   = par_q;
    if (freeze) begin
      state_d = ST_IDLE;
      tcnt_d  = '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (take) begin
            shf_d   = hold_data;
            par_d   = par_calc;
            state_d = ST_START;
            tcnt_d  = '0;
            bit_d   = '0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (tcnt_q == BIT_LAST) begin
              tcnt_d  = '0;
              state_d = ST_DATA;
            end else begin
              tcnt_d = tcnt_q + TC_W'(1);
            end
          end
        end
        ST_DATA: begin
          if (tick) begin
            if (tcnt_q == BIT_LAST) begin
              tcnt_d = '0;
              shf_d  = shf_q >> 1;
              if ({1'b0, bit_q} == nbits - 4'd1) begin
                state_d = par_en ? ST_PAR : ST_STOP;
              end else begin
                bit_d = bit_q + BIT_W'(1);
              end
            end else begin
              tcnt_d = tcnt_q + TC_W'(1);
            end
          end
        end
        ST_PAR: begin
          if (tick) begin
            if (tcnt_q == BIT_LAST) begin
              tcnt_d  = '0;
              state_d = ST_STOP;
            end else begin
              tcnt_d = tcnt_q + TC_W'(1);
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (tcnt_q == stop_last) begin
              tcnt_d  = '0;
              state_d = ST_IDLE;
            end else begin
              tcnt_d = tcnt_q + TC_W'(1);
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tcnt_q  <= '0;
      bit_q   <= '0;
      shf_q   <= '1;
      par_q   <= 1'b1;
    end else begin
      state_q <= state_d;
      tcnt_q  <= tcnt_d;
      bit_q   <= bit_d;
      shf_q   <= shf_d;
      par_q   <= par_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START: frame_line = 1'b0;
      ST_DATA:  frame_line = shf_q[0];
      ST_PAR:   frame_line = par_q;
      default:  frame_line = 1'b1;
    endcase
    if (freeze)   line_o = 1'b1;
    else if (brk) line_o = 1'b0;
    else          line_o = frame_line;
  end

  // R6
  tick_pace_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && !tick && !freeze) |=> $stable(state_q));

  // R9
  freeze_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> (state_q == ST_IDLE));

  // R4
  stop_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP) |-> (tcnt_q < TC_W'(2 * OVS)));

  // R8
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !hold_empty && !freeze) |=> (state_q == ST_START));

endmodule

// File: rtl/sertx_top.sv
module sertx_top #(
  parameter int DIV_W  = 16,
  parameter int DATA_W = 8,
  parameter int OVS    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_ref_en,
  input  logic [DIV_W-1:0]  divisor,
  input  logic [1:0]        wlen_sel,
  input  logic              stop_sel,
  input  logic              par_en,
  input  logic              par_even,
  input  logic              par_stick,
  input  logic              brk,
  input  logic              freeze,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic              ser_out,
  output logic              baud_tick,
  output logic              hold_empty,
  output logic              xmit_empty
);

  logic [1:0]        rs_q;
  logic              rst_n_i;
  logic [DATA_W-1:0] hold_data;
  logic              take;
  logic              busy;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_i = rs_q[1];

  sertx_baud #(.DIV_W(DIV_W)) u_baud (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .ref_en  (baud_ref_en),
    .divisor (divisor),
    .tick_o  (baud_tick)
  );

  sertx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .take    (take),
    .data_o  (hold_data),
    .empty_o (hold_empty)
  );

  sertx_shift #(.DATA_W(DATA_W), .OVS(OVS)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .tick       (baud_tick),
    .freeze     (freeze),
    .brk        (brk),
    .wlen_sel   (wlen_sel),
    .stop_sel   (stop_sel),
    .par_en     (par_en),
    .par_even   (par_even),
    .par_stick  (par_stick),
    .hold_data  (hold_data),
    .hold_empty (hold_empty),
    .take       (take),
    .busy       (busy),
    .line_o     (ser_out)
  );

  assign xmit_empty = hold_empty & ~busy;

endmodule

// File: tb/sim_sertx_top.sv
`timescale 1ns/1ps
module sim_sertx_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        baud_ref_en = 1'b1;
  logic [15:0] divisor = 16'd1;
  logic [1:0]  wlen_sel = 2'b11;
  logic        stop_sel = 1'b0, par_en = 1'b0, par_even = 1'b0, par_stick = 1'b0;
  logic        brk = 1'b0, freeze = 1'b0, wr_en = 1'b0;
  logic [7:0]  wr_data = 8'h00;
  logic        ser_out, baud_tick, hold_empty, xmit_empty;

  int tests = 0;
  int fails = 0;
  int ref_div = 1;
  int ref_ph = 0;
  int cyc = 0;

  sertx_top u0 (
    .clk(clk), .rst_n(rst_n), .baud_ref_en(baud_ref_en), .divisor(divisor),
    .wlen_sel(wlen_sel), .stop_sel(stop_sel), .par_en(par_en), .par_even(par_even),
    .par_stick(par_stick), .brk(brk), .freeze(freeze), .wr_en(wr_en),
    .wr_data(wr_data), .ser_out(ser_out), .baud_tick(baud_tick),
    .hold_empty(hold_empty), .xmit_empty(xmit_empty)
  );

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (ref_div <= 1) begin
      baud_ref_en <= 1'b1;
    end else begin
      baud_ref_en <= (ref_ph == 0);
      ref_ph      <= (ref_ph >= ref_div - 1) ? 0 : ref_ph + 1;
    end
  end

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      fails++;
      tests++;
      $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic config_line(input int nb, input bit pen, input bit eps,
                             input bit stick, input bit stb);
    @(negedge clk);
    wlen_sel = 2'(nb - 5); par_en = pen; par_even = eps;
    par_stick = stick; stop_sel = stb;
  endtask

  // decode one frame at mid-bit using baud_tick, compare with built frame
  task automatic capture(input logic [7:0] d, input int nb, input bit pen,
                         input bit eps, input bit stick, input bit stb,
                         input bit all_low, input bit end_chk, input string req);
    logic [7:0] m;
    logic       pb;
    logic       exp_bits [0:11];
    int         nsamp, total, cnt, guard, bad;
    m  = d & (8'hFF >> (8 - nb));
    pb = stick ? ~eps : (eps ? ^m : ~^m);
    exp_bits[0] = 1'b0;
    for (int i = 0; i < nb; i++) exp_bits[1 + i] = m[i];
    if (pen) exp_bits[1 + nb] = pb;
    for (int i = 1 + nb + int'(pen); i < 12; i++) exp_bits[i] = 1'b1;
    nsamp = 1 + nb + int'(pen) + (stb ? 2 : 1);
    total = 16 * (1 + nb + int'(pen)) + (stb ? ((nb == 5) ? 24 : 32) : 16);
    guard = 0;
    do begin
      @(negedge clk);
      guard++;
    end while (ser_out !== 1'b0 && guard < 5000 && !all_low);
    if (all_low) begin
      guard = 0;
      while (xmit_empty && guard < 5000) begin
        @(negedge clk);
        guard++;
      end
    end
    chk(guard < 5000, req, "frame start seen", guard, 0);
    cnt = 0; bad = 0; guard = 0;
    forever begin
      if (baud_tick) begin
        cnt++;
        if ((cnt % 16) == 8 && (cnt / 16) < nsamp) begin
          if (ser_out !== (all_low ? 1'b0 : exp_bits[cnt / 16])) begin
            bad++;
            $display("FAIL %s bit %0d of 0x%0h: actual=%0b expected=%0b", req,
                     cnt / 16, d, ser_out, all_low ? 1'b0 : exp_bits[cnt / 16]);
          end
        end
      end
      if (cnt == total || guard > 20000) break;
      @(negedge clk);
      guard++;
    end
    tests++;
    if (bad != 0) fails++;
    if (end_chk) begin
      chk(xmit_empty == 1'b0, req, "busy on last stop tick", xmit_empty, 0);
      @(negedge clk);
      chk(xmit_empty == 1'b1, req, "empty right after stop", xmit_empty, 1);
    end
  endtask

  task automatic tick_period(input int exp, input string req);
    int g, n;
    g = 0;
    do begin @(negedge clk); g++; end while (!baud_tick && g < 1000);
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!baud_tick && n < 1000);
      chk(n == exp, req, "tick spacing in clocks", n, exp);
    end
  endtask

  task automatic t_reset;
    chk(ser_out == 1'b1, "R7", "ser_out after reset", ser_out, 1);
    chk(hold_empty == 1'b1, "R7", "hold_empty after reset", hold_empty, 1);
    chk(xmit_empty == 1'b1, "R7", "xmit_empty after reset", xmit_empty, 1);
    chk(baud_tick == 1'b0, "R7", "baud_tick in reset", baud_tick, 0);
  endtask

  task automatic t_baud;
    int seen;
    divisor = 16'd1; ref_div = 1;
    tick_period(1, "R10");
    divisor = 16'd3;
    repeat (8) @(negedge clk);
    tick_period(3, "R10");
    divisor = 16'd2; ref_div = 3;
    repeat (12) @(negedge clk);
    tick_period(6, "R10");
    divisor = 16'd0;
    repeat (4) @(negedge clk);
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (baud_tick) seen++;
    end
    chk(seen == 0, "R6", "ticks with zero divisor", seen, 0);
    ref_div = 1; divisor = 16'd1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_frames;
    config_line(8, 0, 0, 0, 0); write_byte(8'hA5);
    capture(8'hA5, 8, 0, 0, 0, 0, 0, 1, "R1");
    config_line(5, 0, 0, 0, 0); write_byte(8'hE3);
    capture(8'hE3, 5, 0, 0, 0, 0, 0, 1, "R1");
    config_line(7, 1, 1, 0, 0); write_byte(8'h4B);
    capture(8'h4B, 7, 1, 1, 0, 0, 0, 1, "R2");
    config_line(6, 1, 0, 0, 1); write_byte(8'h2D);
    capture(8'h2D, 6, 1, 0, 0, 1, 0, 1, "R2");
    config_line(5, 0, 0, 0, 1); write_byte(8'h15);
    capture(8'h15, 5, 0, 0, 0, 1, 0, 1, "R4");
    config_line(8, 1, 1, 1, 0); write_byte(8'h01);
    capture(8'h01, 8, 1, 1, 1, 0, 0, 1, "R3");
    config_line(8, 1, 0, 1, 0); write_byte(8'h03);
    capture(8'h03, 8, 1, 0, 1, 0, 0, 1, "R3");
    divisor = 16'd3;
    config_line(8, 0, 0, 0, 1); write_byte(8'h96);
    capture(8'h96, 8, 0, 0, 0, 1, 0, 1, "R6");
    divisor = 16'd1;
  endtask

  task automatic t_break;
    config_line(8, 0, 0, 0, 0);
    brk = 1'b1;
    @(negedge clk);
    chk(ser_out == 1'b0, "R5", "line under break while idle", ser_out, 0);
    write_byte(8'hFF);
    capture(8'hFF, 8, 0, 0, 0, 0, 1, 1, "R5");
    brk = 1'b0;
    @(negedge clk);
    chk(ser_out == 1'b1, "R5", "line after break release", ser_out, 1);
  endtask

  task automatic t_double;
    config_line(8, 0, 0, 0, 0);
    write_byte(8'h3C);
    fork
      capture(8'h3C, 8, 0, 0, 0, 0, 0, 0, "R8");
      begin
        repeat (3) @(negedge clk);
        chk(hold_empty == 1'b1, "R8", "hold freed after transfer", hold_empty, 1);
        chk(xmit_empty == 1'b0, "R8", "xmit busy during frame", xmit_empty, 0);
        write_byte(8'hC3);
        chk(hold_empty == 1'b0, "R8", "hold full with second byte", hold_empty, 0);
      end
    join
    chk(xmit_empty == 1'b0, "R8", "xmit busy with byte waiting", xmit_empty, 0);
    capture(8'hC3, 8, 0, 0, 0, 0, 0, 1, "R8");
  endtask

  task automatic t_freeze;
    int hi_bad;
    config_line(8, 0, 0, 0, 0);
    write_byte(8'h00);
    repeat (40) @(negedge clk);
    freeze = 1'b1;
    write_byte(8'h5A);
    hi_bad = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (ser_out !== 1'b1) hi_bad++;
    end
    chk(hi_bad == 0, "R9", "cycles with line low under freeze", hi_bad, 0);
    chk(hold_empty == 1'b0, "R9", "byte kept during freeze", hold_empty, 0);
    freeze = 1'b0;
    capture(8'h5A, 8, 0, 0, 0, 0, 0, 1, "R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_baud();
    t_frames();
    t_break();
    t_double();
    t_freeze();
    repeat (5) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule